// File: doc/BRIEF.md
# Dual-Output DSP Address Generator

This block forms effective memory addresses for a signal-processing core. It keeps six 24-bit address registers, a general offset register that can also serve as an address, an offset-only register, a 16-bit modifier, a dedicated 24-bit stack pointer, and a shadow copy of the first two address registers, the general offset and the modifier. In every cycle two address ALUs work side by side. The primary path takes any address register, the offset register or the stack pointer and steers the result to either the primary data bus or the 21-bit program bus. The secondary path always takes address register 3 and drives the second data bus.

Each path can leave its source register alone, step it by one in either direction, add an offset to it, or present the register plus the general offset without changing the register. The address always shows the value the register held before the update, and the update lands at the clock edge. When the modifier is not all ones, updates of address registers 0 and 1 wrap inside an aligned circular buffer. A write port loads any register directly, and a single strobe swaps the live registers with their shadows in one cycle.

Top module: `addr_gen_dual`

## Requirements
- R1: After reset every address register, both offset registers, the stack pointer and the shadow copies hold 0, and the modifier and its shadow hold 0xFFFF.
- R2: priSel picks the primary source (0 to 5 address registers 0 to 5, 6 the general offset register, 7 the stack pointer). The primary address is that register's value before this cycle's update, or that value plus the general offset when priOp is 5 (indexed), which leaves the register unchanged.
- R3: With priProg high, progAddr carries the low 21 bits of the primary address and priDataAddr is 0. With priProg low, priDataAddr carries the full primary address and progAddr is 0.
- R4: secAddr always comes from address register 3 (plus the general offset when secOp is 5), whatever priSel holds.
- R5: Update codes for priOp and secOp are 0 none, 1 add one, 2 subtract one, 3 add the general offset, 4 add the offset-only register, 5 indexed without update, 6 and 7 none. The new value is visible after the clock edge, and linear updates wrap modulo 2^24.
- R6: priOp 4 leaves every register unchanged. The offset-only register can be added only on the secondary path.
- R7: With modifier value M not equal to 0xFFFF, primary updates of address registers 0 and 1 wrap modulo M+1 inside a buffer whose base is the register with its low bits cleared up to the smallest power of two not below M+1. Step sizes must not exceed M+1.
- R8: Address registers 2 to 5, the general offset register and the stack pointer always update linearly, whatever the modifier holds.
- R9: When the primary path updates register 3 in the same cycle as the secondary path, only the primary result is written.
- R10: wrSel codes are 0 to 5 for address registers 0 to 5, 6 general offset, 7 offset-only, 8 modifier (low 16 bits of wrData), and 9 stack pointer. Codes 10 to 15 change nothing. A write beats any update of the same register in the same cycle.
- R11: swapEn exchanges address registers 0 and 1, the general offset and the modifier with their shadows. Each shadow receives the value its live register would have taken after this cycle's write or update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| priOp | input | 3 | Primary update code |
| priSel | input | 3 | Primary source register select |
| priProg | input | 1 | Steer primary address to the program bus |
| secOp | input | 3 | Secondary update code (acts on register 3) |
| wrEn | input | 1 | Direct register write enable |
| wrSel | input | 4 | Direct write target code |
| wrData | input | 24 | Direct write value |
| swapEn | input | 1 | Swap live registers with their shadows |
| priDataAddr | output | 24 | Primary data bus address |
| progAddr | output | 21 | Program bus address |
| secAddr | output | 24 | Secondary data bus address |
| arOut | output | 6x24 | Address registers 0 to 5 |
| nOut | output | 24 | General offset register |
| n3Out | output | 24 | Offset-only register |
| m01Out | output | 16 | Modifier register |
| spOut | output | 24 | Stack pointer |

## Verification
On every cycle the assertions check several things: an idle cycle holds all state, a secondary increment of register 3 lands exactly, the primary path wins a register 3 conflict, a stack pointer decrement is exact, a modulo step of register 0 stays inside its buffer, and a swap brings back the shadow values. The bench scenarios cover what needs known values. These are the wrap points of a ten-entry circular buffer in both directions and with an offset step, the 21-bit truncation on the program bus, the ignored write codes, the write-over-update priority, and shadow contents that can only be seen by swapping them back in.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

  localparam int NUM_AR   = 6;   // address registers 0..5
  localparam int NUM_SLOT = 8;   // primary sources: AR0..AR5, N, SP
  localparam int NUM_WR   = 10;  // direct write targets
  localparam int SLOT_N   = 6;
  localparam int SLOT_SP  = 7;
  localparam int WR_N     = 6;
  localparam int WR_N3    = 7;
  localparam int WR_M01   = 8;
  localparam int WR_SP    = 9;
  localparam int SEC_AR   = 3;   // secondary path is tied to this register

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_INC   = 3'd1,
    OP_DEC   = 3'd2,
    OP_ADDN  = 3'd3,
    OP_ADDN3 = 3'd4,
    OP_IDXN  = 3'd5
  } agOp_e;

  typedef enum logic [1:0] {
    STEP_INC,
    STEP_DEC,
    STEP_ADDN,
    STEP_ADDN3
  } stepSel_e;

  typedef struct packed {
    logic [2:0]          priSlot;
    logic [NUM_SLOT-1:0] priUpd;
    stepSel_e            priStep;
    logic                priIdx;
    logic                priProg;
    logic                secUpd;
    stepSel_e            secStep;
    logic                secIdx;
    logic [NUM_WR-1:0]   wrHit;
    logic                swap;
  } agStrobe_t;

endpackage

// File: rtl/addr_gen_upd.sv
module addr_gen_upd #(
  parameter int AW = 24,
  parameter int MW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic          modEn,
  input  logic [MW-1:0] modVal,
  output logic [AW-1:0] nxt
);
  localparam int SW = AW + 1;

  logic [AW-1:0]        mask;
  logic [AW-1:0]        off;
  logic [AW-1:0]        base;
  logic                 modOn;
  logic signed [SW-1:0] sumS;
  logic signed [SW-1:0] lim;
  logic signed [SW-1:0] wrapS;

  // buffer mask: all bits at or below the top set bit of the modifier
  always_comb begin
    mask = '0;
    for (int i = 0; i < MW; i++) mask[i] = |(modVal >> i);
  end

  assign modOn = modEn && (modVal != '1);
  assign off   = cur & mask;
  assign base  = cur & ~mask;
  assign sumS  = $signed({1'b0, off}) + $signed({step[AW-1], step});
  assign lim   = $signed({{(SW-MW){1'b0}}, modVal});

  always_comb begin
    if (sumS > lim)            wrapS = sumS - lim - SW'(1);
    else if (sumS < SW'(0))    wrapS = sumS + lim + SW'(1);
    else                       wrapS = sumS;
  end

  assign nxt = modOn ? (base | (AW'(wrapS) & mask)) : (cur + step);

endmodule

// File: rtl/addr_gen_ctrl.sv
module addr_gen_ctrl
  import addr_gen_pkg::*;
(
  input  logic      [2:0] priOp,
  input  logic      [2:0] priSel,
  input  logic            priProg,
  input  logic      [2:0] secOp,
  input  logic            wrEn,
  input  logic      [3:0] wrSel,
  input  logic            swapEn,
  output agStrobe_t       strb
);
  agOp_e               opP, opS;
  logic                priDoUpd, secDoUpd;
  logic [NUM_SLOT-1:0] priUpdRaw;
  logic [NUM_WR-1:0]   wrHitRaw;

  assign opP = agOp_e'(priOp);
  assign opS = agOp_e'(secOp);

  always_comb begin
    priDoUpd     = 1'b0;
    strb.priStep = STEP_INC;
    strb.priIdx  = 1'b0;
    unique case (opP)
      OP_INC:  begin priDoUpd = 1'b1; strb.priStep = STEP_INC;  end
      OP_DEC:  begin priDoUpd = 1'b1; strb.priStep = STEP_DEC;  end
      OP_ADDN: begin priDoUpd = 1'b1; strb.priStep = STEP_ADDN; end
      OP_IDXN: strb.priIdx = 1'b1;
      default: ;  // none, and add-N3 which the primary path lacks
    endcase
  end

  always_comb begin
    secDoUpd     = 1'b0;
    strb.secStep = STEP_INC;
    strb.secIdx  = 1'b0;
    unique case (opS)
      OP_INC:   begin secDoUpd = 1'b1; strb.secStep = STEP_INC;   end
      OP_DEC:   begin secDoUpd = 1'b1; strb.secStep = STEP_DEC;   end
      OP_ADDN:  begin secDoUpd = 1'b1; strb.secStep = STEP_ADDN;  end
      OP_ADDN3: begin secDoUpd = 1'b1; strb.secStep = STEP_ADDN3; end
      OP_IDXN:  strb.secIdx = 1'b1;
      default: ;
    endcase
  end

  assign priUpdRaw = priDoUpd ? (NUM_SLOT'(1) << priSel) : '0;
  // codes at or above NUM_WR shift out of range and hit nothing
  assign wrHitRaw  = wrEn ? (NUM_WR'(1) << wrSel) : '0;

  // a direct write masks any update of the same register
  always_comb begin
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (i == SLOT_SP) strb.priUpd[i] = priUpdRaw[i] && !wrHitRaw[WR_SP];
      else              strb.priUpd[i] = priUpdRaw[i] && !wrHitRaw[i];
    end
  end

  // primary wins over secondary on the shared register
  assign strb.secUpd  = secDoUpd && !priUpdRaw[SEC_AR] && !wrHitRaw[SEC_AR];
  assign strb.priSlot = priSel;
  assign strb.priProg = priProg;
  assign strb.wrHit   = wrHitRaw;
  assign strb.swap    = swapEn;

endmodule

// File: rtl/addr_gen_dp.sv
module addr_gen_dp
  import addr_gen_pkg::*;
#(
  parameter int AW = 24,
  parameter int PW = 21,
  parameter int MW = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  agStrobe_t                    strb,
  input  logic [AW-1:0]                wrData,
  output logic [AW-1:0]                priDataAddr,
  output logic [PW-1:0]                progAddr,
  output logic [AW-1:0]                secAddr,
  output logic [NUM_AR-1:0][AW-1:0]    arOut,
  output logic [AW-1:0]                nOut,
  output logic [AW-1:0]                n3Out,
  output logic [MW-1:0]                m01Out,
  output logic [AW-1:0]                spOut
);
  logic [NUM_AR-1:0][AW-1:0] arReg, arNext;
  logic [AW-1:0] nReg, n3Reg, spReg, nNext, n3Next, spNext;
  logic [MW-1:0] m01Reg, m01Next;
  logic [AW-1:0] sh0, sh1, shN;
  logic [MW-1:0] shM;
  logic [AW-1:0] priCur, priEff, priStepVal, secStepVal, priNew, secNew;

  function automatic logic [AW-1:0] stepOf(input stepSel_e s, input logic [AW-1:0] n,
                                           input logic [AW-1:0] n3);
    unique case (s)
      STEP_INC:  stepOf = AW'(1);
      STEP_DEC:  stepOf = '1;
      STEP_ADDN: stepOf = n;
      default:   stepOf = n3;
    endcase
  endfunction

  // primary source mux
  always_comb begin
    unique case (strb.priSlot)
      3'd0: priCur = arReg[0];
      3'd1: priCur = arReg[1];
      3'd2: priCur = arReg[2];
      3'd3: priCur = arReg[3];
      3'd4: priCur = arReg[4];
      3'd5: priCur = arReg[5];
      3'd6: priCur = nReg;
      default: priCur = spReg;
    endcase
  end

  assign priEff      = strb.priIdx ? priCur + nReg : priCur;
  assign priDataAddr = strb.priProg ? '0 : priEff;
  assign progAddr    = strb.priProg ? priEff[PW-1:0] : '0;
  assign secAddr     = strb.secIdx ? arReg[SEC_AR] + nReg : arReg[SEC_AR];

  assign priStepVal = stepOf(strb.priStep, nReg, n3Reg);
  assign secStepVal = stepOf(strb.secStep, nReg, n3Reg);

  // primary ALU: modulo allowed for registers 0 and 1
  addr_gen_upd #(.AW(AW), .MW(MW)) priUpd_i (
    .cur(priCur), .step(priStepVal),
    .modEn(strb.priUpd[0] | strb.priUpd[1]),
    .modVal(m01Reg), .nxt(priNew)
  );

  // secondary ALU: always linear
  addr_gen_upd #(.AW(AW), .MW(MW)) secUpd_i (
    .cur(arReg[SEC_AR]), .step(secStepVal),
    .modEn(1'b0), .modVal(m01Reg), .nxt(secNew)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_AR; g++) begin : gArNext
      if (g == SEC_AR) begin : gSec
        assign arNext[g] = strb.wrHit[g]  ? wrData :
                           strb.priUpd[g] ? priNew :
                           strb.secUpd    ? secNew : arReg[g];
      end else begin : gPri
        assign arNext[g] = strb.wrHit[g]  ? wrData :
                           strb.priUpd[g] ? priNew : arReg[g];
      end
    end
  endgenerate

  assign nNext   = strb.wrHit[WR_N]   ? wrData : strb.priUpd[SLOT_N]  ? priNew : nReg;
  assign spNext  = strb.wrHit[WR_SP]  ? wrData : strb.priUpd[SLOT_SP] ? priNew : spReg;
  assign n3Next  = strb.wrHit[WR_N3]  ? wrData : n3Reg;
  assign m01Next = strb.wrHit[WR_M01] ? wrData[MW-1:0] : m01Reg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arReg  <= '0;
      nReg   <= '0;
      n3Reg  <= '0;
      spReg  <= '0;
      m01Reg <= '1;
      sh0    <= '0;
      sh1    <= '0;
      shN    <= '0;
      shM    <= '1;
    end else begin
      arReg[NUM_AR-1:2] <= arNext[NUM_AR-1:2];
      n3Reg  <= n3Next;
      spReg  <= spNext;
      arReg[0] <= strb.swap ? sh0 : arNext[0];
      arReg[1] <= strb.swap ? sh1 : arNext[1];
      nReg     <= strb.swap ? shN : nNext;
      m01Reg   <= strb.swap ? shM : m01Next;
      if (strb.swap) begin
        sh0 <= arNext[0];
        sh1 <= arNext[1];
        shN <= nNext;
        shM <= m01Next;
      end
    end
  end

  assign arOut  = arReg;
  assign nOut   = nReg;
  assign n3Out  = n3Reg;
  assign m01Out = m01Reg;
  assign spOut  = spReg;

  // ---------------- assertions ----------------
  function automatic logic [AW-1:0] maskOf(input logic [MW-1:0] m);
    maskOf = '0;
    for (int i = 0; i < MW; i++) maskOf[i] = |(m >> i);
  endfunction

  logic idleCyc;
  assign idleCyc = !(|strb.priUpd) && !strb.secUpd && !(|strb.wrHit) && !strb.swap;

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    idleCyc |=> ($stable(arReg) && $stable(nReg) && $stable(n3Reg) &&
                 $stable(spReg) && $stable(m01Reg)));

  assert_sec_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.secUpd && strb.secStep == STEP_INC) |=>
      arReg[SEC_AR] == $past(arReg[SEC_AR]) + AW'(1));

  assert_sp_dec_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.priUpd[SLOT_SP] && strb.priStep == STEP_DEC) |=>
      spReg == $past(spReg) - AW'(1));

  assert_mod_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.priUpd[0] && !strb.swap && m01Reg != '1 &&
     (strb.priStep == STEP_INC || strb.priStep == STEP_DEC) &&
     ((arReg[0] & maskOf(m01Reg)) <= AW'(m01Reg))) |=>
      (((arReg[0] & ~maskOf($past(m01Reg))) == ($past(arReg[0]) & ~maskOf($past(m01Reg)))) &&
       ((arReg[0] & maskOf($past(m01Reg))) <= AW'($past(m01Reg)))));

  assert_swap_restore_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.swap |=> (arReg[0] == $past(sh0) && arReg[1] == $past(sh1) &&
                   nReg == $past(shN) && m01Reg == $past(shM)));

endmodule

// File: rtl/addr_gen_dual.sv
module addr_gen_dual
  import addr_gen_pkg::*;
#(
  parameter int AW = 24,
  parameter int PW = 21,
  parameter int MW = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [2:0]                priOp,
  input  logic [2:0]                priSel,
  input  logic                      priProg,
  input  logic [2:0]                secOp,
  input  logic                      wrEn,
  input  logic [3:0]                wrSel,
  input  logic [AW-1:0]             wrData,
  input  logic                      swapEn,
  output logic [AW-1:0]             priDataAddr,
  output logic [PW-1:0]             progAddr,
  output logic [AW-1:0]             secAddr,
  output logic [NUM_AR-1:0][AW-1:0] arOut,
  output logic [AW-1:0]             nOut,
  output logic [AW-1:0]             n3Out,
  output logic [MW-1:0]             m01Out,
  output logic [AW-1:0]             spOut
);
  agStrobe_t strb;

  addr_gen_ctrl ctrl_i (
    .priOp(priOp), .priSel(priSel), .priProg(priProg), .secOp(secOp),
    .wrEn(wrEn), .wrSel(wrSel), .swapEn(swapEn), .strb(strb)
  );

  addr_gen_dp #(.AW(AW), .PW(PW), .MW(MW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .priDataAddr(priDataAddr), .progAddr(progAddr), .secAddr(secAddr),
    .arOut(arOut), .nOut(nOut), .n3Out(n3Out), .m01Out(m01Out), .spOut(spOut)
  );

  // primary increment of register 3 wins over any secondary request
  assert_pri_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (priOp == 3'd1 && priSel == 3'd3 && secOp != 3'd0 && !(wrEn && wrSel == 4'd3)) |=>
      arOut[3] == $past(arOut[3]) + AW'(1));

endmodule

// File: tb/addr_gen_dual_tb.sv
module addr_gen_dual_tb_top;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  priOp, priSel, secOp;
  logic        priProg, wrEn, swapEn;
  logic [3:0]  wrSel;
  logic [23:0] wrData;
  logic [23:0] priDataAddr, secAddr, nOut, n3Out, spOut;
  logic [20:0] progAddr;
  logic [5:0][23:0] arOut;
  logic [15:0] m01Out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  addr_gen_dual dut_i (
    .clk(clk), .rstN(rstN), .priOp(priOp), .priSel(priSel), .priProg(priProg),
    .secOp(secOp), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .swapEn(swapEn),
    .priDataAddr(priDataAddr), .progAddr(progAddr), .secAddr(secAddr),
    .arOut(arOut), .nOut(nOut), .n3Out(n3Out), .m01Out(m01Out), .spOut(spOut)
  );

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %06h expected %06h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    priOp = 3'd0; priSel = 3'd0; priProg = 1'b0; secOp = 3'd0;
    wrEn = 1'b0; wrSel = 4'd0; wrData = '0; swapEn = 1'b0;
  endtask

  task automatic wrReg(input logic [3:0] s, input logic [23:0] d);
    wrEn = 1'b1; wrSel = s; wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic priDo(input logic [2:0] op, input logic [2:0] sel);
    priOp = op; priSel = sel;
    cyc();
    priOp = 3'd0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; idle();
    repeat (3) cyc();
    rstN = 1'b1;
    #1;
    for (int i = 0; i < 6; i++) chk("R1 address register", arOut[i], 24'h0);
    chk("R1 N", nOut, 24'h0);
    chk("R1 N3", n3Out, 24'h0);
    chk("R1 SP", spOut, 24'h0);
    chk("R1 modifier", {8'h0, m01Out}, 24'h00FFFF);
  endtask

  task automatic t_write();
    wrReg(4'd2, 24'h123456);
    wrReg(4'd6, 24'h000010);
    wrReg(4'd7, 24'h000003);
    wrReg(4'd9, 24'h000100);
    chk("R10 write AR2", arOut[2], 24'h123456);
    chk("R10 write N", nOut, 24'h000010);
    chk("R10 write N3", n3Out, 24'h000003);
    chk("R10 write SP", spOut, 24'h000100);
    wrReg(4'd8, 24'hAB1234);
    chk("R10 write modifier low bits", {8'h0, m01Out}, 24'h001234);
    wrReg(4'd8, 24'h00FFFF);
    wrReg(4'd12, 24'hFFFFFF);  // unused code
    chk("R10 ignored code AR2", arOut[2], 24'h123456);
    chk("R10 ignored code N", nOut, 24'h000010);
    chk("R10 ignored code SP", spOut, 24'h000100);
    chk("R10 ignored code modifier", {8'h0, m01Out}, 24'h00FFFF);
  endtask

  task automatic t_primary();
    wrReg(4'd5, 24'h3ABCDE);
    priSel = 3'd2; priProg = 1'b0; #1;
    chk("R2 data address AR2", priDataAddr, 24'h123456);
    chk("R3 program bus idle", {3'b0, progAddr}, 24'h0);
    priSel = 3'd5; priProg = 1'b1; #1;
    chk("R3 program bus low 21 bits", {3'b0, progAddr}, 24'h1ABCDE);
    chk("R3 data bus idle", priDataAddr, 24'h0);
    priProg = 1'b0; priSel = 3'd6; #1;
    chk("R2 source N", priDataAddr, 24'h000010);
    priSel = 3'd7; #1;
    chk("R2 source SP", priDataAddr, 24'h000100);
    priSel = 3'd2; priOp = 3'd5; #1;
    chk("R2 indexed address", priDataAddr, 24'h123466);
    cyc(); priOp = 3'd0;
    chk("R2 indexed no update", arOut[2], 24'h123456);
  endtask

  task automatic t_update();
    priOp = 3'd1; priSel = 3'd2; #1;
    chk("R2 pre-update address", priDataAddr, 24'h123456);
    cyc(); priOp = 3'd0;
    chk("R5 increment", arOut[2], 24'h123457);
    priDo(3'd2, 3'd5);
    chk("R5 decrement", arOut[5], 24'h3ABCDD);
    priDo(3'd3, 3'd2);
    chk("R5 add N", arOut[2], 24'h123467);
    wrReg(4'd4, 24'hFFFFFF);
    priDo(3'd1, 3'd4);
    chk("R5 wrap at 2^24", arOut[4], 24'h000000);
    priDo(3'd4, 3'd2);
    chk("R6 primary add N3 ignored", arOut[2], 24'h123467);
    priDo(3'd2, 3'd7);
    chk("R8 SP decrement", spOut, 24'h0000FF);
    priDo(3'd6, 3'd2);
    chk("R5 code 6 no update", arOut[2], 24'h123467);
  endtask

  task automatic t_secondary();
    wrReg(4'd3, 24'h000500);
    priSel = 3'd2; #1;
    chk("R4 secondary from AR3", secAddr, 24'h000500);
    secOp = 3'd4; cyc(); secOp = 3'd0;
    chk("R4 secondary add N3", arOut[3], 24'h000503);
    secOp = 3'd1; cyc(); secOp = 3'd0;
    chk("R4 secondary increment", arOut[3], 24'h000504);
    secOp = 3'd5; #1;
    chk("R4 secondary indexed", secAddr, 24'h000514);
    cyc(); secOp = 3'd0;
    chk("R4 secondary indexed no update", arOut[3], 24'h000504);
  endtask

  task automatic t_modulo();
    wrReg(4'd8, 24'h000009);          // modulo 10, 16-word buffer
    wrReg(4'd0, 24'h000108);
    priDo(3'd1, 3'd0);
    chk("R7 modulo step inside", arOut[0], 24'h000109);
    priDo(3'd1, 3'd0);
    chk("R7 modulo wrap up", arOut[0], 24'h000100);
    priDo(3'd2, 3'd0);
    chk("R7 modulo wrap down", arOut[0], 24'h000109);
    wrReg(4'd0, 24'h000107);
    wrReg(4'd6, 24'h000004);
    priDo(3'd3, 3'd0);
    chk("R7 modulo add N wrap", arOut[0], 24'h000101);
    wrReg(4'd1, 24'h000200);
    priDo(3'd2, 3'd1);
    chk("R7 modulo AR1 wrap down", arOut[1], 24'h000209);
    wrReg(4'd2, 24'h00010F);
    priDo(3'd1, 3'd2);
    chk("R8 AR2 linear under modifier", arOut[2], 24'h000110);
    priDo(3'd3, 3'd6);
    chk("R8 N linear update", nOut, 24'h000008);
    wrReg(4'd8, 24'h00FFFF);
    wrReg(4'd0, 24'h000109);
    priDo(3'd1, 3'd0);
    chk("R7 all ones is linear", arOut[0], 24'h00010A);
  endtask

  task automatic t_conflict();
    wrReg(4'd3, 24'h000500);
    priOp = 3'd1; priSel = 3'd3; secOp = 3'd2;
    cyc(); idle();
    chk("R9 primary wins on AR3", arOut[3], 24'h000501);
    wrEn = 1'b1; wrSel = 4'd3; wrData = 24'h000777;
    priOp = 3'd1; priSel = 3'd3; secOp = 3'd1;
    cyc(); idle();
    chk("R10 write beats updates", arOut[3], 24'h000777);
  endtask

  task automatic t_swap();
    wrReg(4'd0, 24'hA0A0A0);
    wrReg(4'd1, 24'hB1B1B1);
    wrReg(4'd6, 24'h000020);
    wrReg(4'd8, 24'h000007);
    swapEn = 1'b1; cyc(); swapEn = 1'b0;
    chk("R11 swap in AR0", arOut[0], 24'h0);
    chk("R11 swap in AR1", arOut[1], 24'h0);
    chk("R11 swap in N", nOut, 24'h0);
    chk("R11 swap in modifier", {8'h0, m01Out}, 24'h00FFFF);
    chk("R11 AR2 untouched", arOut[2], 24'h000110);
    swapEn = 1'b1; priOp = 3'd1; priSel = 3'd0;
    cyc(); idle();
    chk("R11 swap back AR0", arOut[0], 24'hA0A0A0);
    chk("R11 swap back AR1", arOut[1], 24'hB1B1B1);
    chk("R11 swap back N", nOut, 24'h000020);
    chk("R11 swap back modifier", {8'h0, m01Out}, 24'h000007);
    swapEn = 1'b1; cyc(); swapEn = 1'b0;
    chk("R11 shadow took updated AR0", arOut[0], 24'h000001);
    chk("R11 shadow modifier", {8'h0, m01Out}, 24'h00FFFF);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_write();
    t_primary();
    t_update();
    t_secondary();
    t_modulo();
    t_conflict();
    t_swap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule